// File: doc/BRIEF.md
# Multi-Port GPIO Controller With Edge Interrupts

This block is a register-mapped general-purpose I/O controller. It holds from one to seven ports of eight pins each and sits on a plain 32-bit register bus with a single write strobe and a combinational read path. Software uses it to drive pads, read back pad levels, and take interrupts.

Each pin has a 2-bit drive mode: input, push-pull, open-drain or open-source. The mode decides when the pad driver is enabled. Each pin also has an output value, a pull-up disable bit and a single-edge interrupt detector whose polarity is chosen per pin. Pad inputs pass through a two-flop synchronizer before software reads them or the edge detector uses them. A detected edge sets a sticky event flag, and software clears the flag by writing a one to it. A per-port force register sets event flags directly for testing. Each port drives one interrupt line, which is the OR over its pins of event AND enable.

A global control word at byte address 0x00 reports the port count and a version number. Its bit 0 is a clock-request bit that gates edge detection through a small gating state machine. The machine has three states. GS_OFF is entered on reset and whenever the clock-request bit is 0. GS_ARM lasts one settle cycle after the bit goes to 1, so the synchronizer history is refreshed. GS_RUN is the only state in which edges set flags. Its transitions are: OFF to ARM when the request bit is 1; ARM to RUN when the bit is still 1; ARM or RUN back to OFF when the bit is 0; RUN stays in RUN while the bit is 1.

Top module: `mpgpio_ctrl`

## Requirements
- R1: After reset, every port register reads 0 and `pad_oe` and `irq` are all 0. `pad_pull_en` is all 1 (pull-ups active). The control word reads only its read-only fields.
- R2: The control word at byte address 0x00 reads back as follows: the port count in bits 15:9, the VERSION parameter in bits 8:2, and the two writable bits 1:0 (bit 1 sync select, bit 0 clock request). All other bits read 0.
- R3: The pin mode register holds 2 bits per pin, with pin b at bits 2b+1:2b. The codes drive the pad as follows. Code 0 (input) never enables the driver. Code 1 (push-pull) always enables it. Code 2 (open-drain) enables it only when the pin's output bit is 0. Code 3 (open-source) enables it only when the pin's output bit is 1. `pad_out` always equals the output data bit.
- R4: `pad_pull_en` for a pin is the inverse of that pin's bit in the pull-up disable register, so a 1 in the register turns the pull-up off.
- R5: The input data register returns the pad levels delayed by two clock edges: a pad change made before edge k is readable after edge k+1 and not after edge k.
- R6: With the pin's edge-select bit at 1, a rising pad edge sets that pin's event flag. With the bit at 0, a falling edge sets it. The other edge, and every other pin, leaves the flags unchanged.
- R7: Writing the event register clears exactly the flags written as 1. Flags written as 0 keep their value.
- R8: A port's `irq` bit is 1 exactly when some pin of that port has both its event flag and its enable bit set.
- R9: While a force register bit is 1, the matching event flag is held set even against a clear. Writing 0 to the force register stops forcing, and the flags can then be cleared.
- R10: Edges set no flags while the clock-request bit is 0. After the bit is set, edge detection resumes after the ARM settle cycle, and a pad level that changed while gated creates no event.
- R11: Byte offsets within a port (stride 0x30) are: 0x04 input data, 0x08 output data, 0x0C pin mode, 0x10 pull-up disable, 0x14 event, 0x18 enable, 0x1C force, 0x20 edge select. Unaligned addresses, unused offsets and ports beyond NPORTS read 0 and ignore writes.
- R12: If an edge sets a flag in the same cycle that software clears it, the flag ends up set.
- R13: The writable port registers read back what was written, masked to their widths: 16 bits for pin mode and 8 bits for the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pad_in | input | NPORTS*8 | Raw pad input levels |
| pad_oe | output | NPORTS*8 | Pad driver enable per pin |
| pad_out | output | NPORTS*8 | Pad output value per pin |
| pad_pull_en | output | NPORTS*8 | Pull-up enable per pin |
| irq | output | NPORTS | One interrupt line per port |

## Verification
The bench builds the block with NPORTS = 2 and VERSION = 3. This keeps the full cross of 16 pins, 4 drive codes and several output patterns small enough to sweep completely. It also puts a real second port and an unimplemented third port window within reach of the decode checks. Every pin is driven through both edge polarities in both directions. The set-versus-clear collision and the gating state machine's settle cycle are timed edge by edge against the two-flop input latency.

// File: rtl/mpgpio_pkg.sv
package mpgpio_pkg;
    localparam int PIN_PER_PORT = 8;
    localparam int MAX_PORTS    = 7;
    localparam int PORT_STRIDE  = 48;

    localparam logic [5:0] OFF_CTRL = 6'h00;
    localparam logic [5:0] OFF_DIN  = 6'h04;
    localparam logic [5:0] OFF_DOUT = 6'h08;
    localparam logic [5:0] OFF_MODE = 6'h0C;
    localparam logic [5:0] OFF_PUD  = 6'h10;
    localparam logic [5:0] OFF_EVT  = 6'h14;
    localparam logic [5:0] OFF_IEN  = 6'h18;
    localparam logic [5:0] OFF_FRC  = 6'h1C;
    localparam logic [5:0] OFF_EDGE = 6'h20;

    typedef enum logic [1:0] {
        GS_OFF = 2'd0,
        GS_ARM = 2'd1,
        GS_RUN = 2'd2
    } gate_state_e;

    typedef enum logic [1:0] {
        PM_INPUT    = 2'd0,
        PM_PUSHPULL = 2'd1,
        PM_DRAIN    = 2'd2,
        PM_SOURCE   = 2'd3
    } pin_mode_e;
endpackage

// File: rtl/mpgpio_sync.sv
module mpgpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/mpgpio_gate_fsm.sv
module mpgpio_gate_fsm
    import mpgpio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_req,
    output gate_state_e state_q,
    output logic        run
);
    gate_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_OFF:  state_d = clk_req ? GS_ARM : GS_OFF;
            GS_ARM:  state_d = clk_req ? GS_RUN : GS_OFF;
            GS_RUN:  state_d = clk_req ? GS_RUN : GS_OFF;
            default: state_d = GS_OFF;
        endcase
    end

    always_comb begin
        run = 1'b0;
        unique case (state_q)
            GS_OFF:  run = 1'b0;
            GS_ARM:  run = 1'b0;
            GS_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end
endmodule

// File: rtl/mpgpio_port.sv
module mpgpio_port
    import mpgpio_pkg::*;
#(
    parameter int PINS = PIN_PER_PORT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [5:0]        off,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              run,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_pull_en,
    output logic              irq,
    output logic [2*PINS-1:0] mode_o,
    output logic [PINS-1:0]   evt_o,
    output logic [PINS-1:0]   frc_o
);
    localparam int MW = 2 * PINS;

    logic [PINS-1:0] dout_q, pud_q, evt_q, ien_q, frc_q, edge_q;
    logic [MW-1:0]   mode_q;
    logic [PINS-1:0] lvl_q, prev_q, hit, clr;
    logic            wen;

    assign wen = sel && wr;

    mpgpio_sync #(.W(PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (lvl_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_q;
    end

    // rising when edge bit is 1, falling when 0, only while the block runs
    always_comb begin
        for (int b = 0; b < PINS; b++) begin
            hit[b] = run && (edge_q[b] ? (lvl_q[b] && !prev_q[b])
                                       : (!lvl_q[b] && prev_q[b]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            mode_q <= '0;
            pud_q  <= '0;
            ien_q  <= '0;
            frc_q  <= '0;
            edge_q <= '0;
        end else if (wen) begin
            case (off)
                OFF_DOUT: dout_q <= wdata[PINS-1:0];
                OFF_MODE: mode_q <= wdata[MW-1:0];
                OFF_PUD:  pud_q  <= wdata[PINS-1:0];
                OFF_IEN:  ien_q  <= wdata[PINS-1:0];
                OFF_FRC:  frc_q  <= wdata[PINS-1:0];
                OFF_EDGE: edge_q <= wdata[PINS-1:0];
                default:  ;
            endcase
        end
    end

    assign clr = (wen && off == OFF_EVT) ? wdata[PINS-1:0] : '0;

    // set sources win over the clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr) | hit | frc_q;
    end

    always_comb begin
        rdata = '0;
        if (sel) begin
            case (off)
                OFF_DIN:  rdata[PINS-1:0] = lvl_q;
                OFF_DOUT: rdata[PINS-1:0] = dout_q;
                OFF_MODE: rdata[MW-1:0]   = mode_q;
                OFF_PUD:  rdata[PINS-1:0] = pud_q;
                OFF_EVT:  rdata[PINS-1:0] = evt_q;
                OFF_IEN:  rdata[PINS-1:0] = ien_q;
                OFF_FRC:  rdata[PINS-1:0] = frc_q;
                OFF_EDGE: rdata[PINS-1:0] = edge_q;
                default:  rdata = '0;
            endcase
        end
    end

    always_comb begin
        for (int b = 0; b < PINS; b++) begin
            unique case (pin_mode_e'(mode_q[2*b +: 2]))
                PM_INPUT:    pad_oe[b] = 1'b0;
                PM_PUSHPULL: pad_oe[b] = 1'b1;
                PM_DRAIN:    pad_oe[b] = !dout_q[b];
                PM_SOURCE:   pad_oe[b] = dout_q[b];
                default:     pad_oe[b] = 1'b0;
            endcase
        end
    end

    assign pad_out     = dout_q;
    assign pad_pull_en = ~pud_q;
    assign irq         = |(evt_q & ien_q);
    assign mode_o      = mode_q;
    assign evt_o       = evt_q;
    assign frc_o       = frc_q;
endmodule

// File: rtl/mpgpio_ctrl.sv
module mpgpio_ctrl
    import mpgpio_pkg::*;
#(
    parameter int         NPORTS  = 7,
    parameter logic [6:0] VERSION = 7'd3,
    parameter int         ADDR_W  = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPORTS*8-1:0]   pad_in,
    output logic [NPORTS*8-1:0]   pad_oe,
    output logic [NPORTS*8-1:0]   pad_out,
    output logic [NPORTS*8-1:0]   pad_pull_en,
    output logic [NPORTS-1:0]     irq
);
    localparam int NPINS = NPORTS * PIN_PER_PORT;
    localparam int MW    = 2 * PIN_PER_PORT;

    logic [1:0]          ctrl_q;
    logic                aligned, cr_hit, run;
    gate_state_e         gate_state;
    logic [31:0]         port_rd [NPORTS];
    logic [2*NPINS-1:0]  mode_all;
    logic [NPINS-1:0]    evt_all, frc_all;

    assign aligned = (bus_addr[1:0] == 2'b00);
    assign cr_hit  = aligned && (bus_addr == ADDR_W'(OFF_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               ctrl_q <= '0;
        else if (bus_wr && cr_hit) ctrl_q <= bus_wdata[1:0];
    end

    mpgpio_gate_fsm u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_req (ctrl_q[0]),
        .state_q (gate_state),
        .run     (run)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam int BASE = p * PORT_STRIDE;
        logic [ADDR_W-1:0] rel;
        logic              hit;

        // wraparound keeps addresses below BASE out of range
        assign rel = bus_addr - ADDR_W'(BASE);
        assign hit = aligned && (rel < ADDR_W'(PORT_STRIDE));

        mpgpio_port #(.PINS(PIN_PER_PORT)) u_port (
            .clk         (clk),
            .rst_n       (rst_n),
            .sel         (hit),
            .wr          (bus_wr),
            .off         (rel[5:0]),
            .wdata       (bus_wdata),
            .rdata       (port_rd[p]),
            .run         (run),
            .pad_in      (pad_in[p*PIN_PER_PORT +: PIN_PER_PORT]),
            .pad_oe      (pad_oe[p*PIN_PER_PORT +: PIN_PER_PORT]),
            .pad_out     (pad_out[p*PIN_PER_PORT +: PIN_PER_PORT]),
            .pad_pull_en (pad_pull_en[p*PIN_PER_PORT +: PIN_PER_PORT]),
            .irq         (irq[p]),
            .mode_o      (mode_all[p*MW +: MW]),
            .evt_o       (evt_all[p*PIN_PER_PORT +: PIN_PER_PORT]),
            .frc_o       (frc_all[p*PIN_PER_PORT +: PIN_PER_PORT])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (cr_hit) bus_rdata = {16'b0, 7'(NPORTS), VERSION, ctrl_q};
        for (int p = 0; p < NPORTS; p++) bus_rdata = bus_rdata | port_rd[p];
    end
endmodule

// File: rtl/mpgpio_ctrl_chk.sv
module mpgpio_ctrl_chk
    import mpgpio_pkg::*;
#(
    parameter int NPINS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input gate_state_e        state,
    input logic [2*NPINS-1:0] mode_all,
    input logic [NPINS-1:0]   evt_all,
    input logic [NPINS-1:0]   frc_all,
    input logic [NPINS-1:0]   pad_oe,
    input logic [NPINS-1:0]   pad_out
);
    // R10: RUN is only reachable through ARM
    a_r10_run_after_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GS_RUN) |-> ($past(state) != GS_OFF));

    // R10: with the block gated and nothing forced, no new flag appears
    a_r10_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state != GS_RUN && frc_all == '0) |=> ((evt_all & ~$past(evt_all)) == '0));

    // R9 and R12: a forced bit is set on the next cycle whatever was written
    a_r9_force_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (frc_all != '0) |=> ((evt_all & $past(frc_all)) == $past(frc_all)));

    // R6: a new flag needs a running detector or a force
    a_r6_flag_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_all & ~$past(evt_all)) != '0) |-> ($past(state) == GS_RUN || $past(frc_all) != '0));

    for (genvar b = 0; b < NPINS; b++) begin : g_pin
        // R3: input mode never drives the pad
        a_r3_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_all[2*b +: 2] == 2'd0) |-> !pad_oe[b]);
        // R3: open-drain only ever drives low
        a_r3_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_all[2*b +: 2] == 2'd2 && pad_oe[b]) |-> !pad_out[b]);
        // R3: open-source only ever drives high
        a_r3_source_high: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_all[2*b +: 2] == 2'd3 && pad_oe[b]) |-> pad_out[b]);
    end
endmodule

bind mpgpio_ctrl mpgpio_ctrl_chk #(.NPINS(NPORTS * 8)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (gate_state),
    .mode_all (mode_all),
    .evt_all  (evt_all),
    .frc_all  (frc_all),
    .pad_oe   (pad_oe),
    .pad_out  (pad_out)
);

// File: tb/mpgpio_ctrl_tb.sv
module mpgpio_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int NPIN = NP * 8;
    localparam int AW = 12;
    localparam int STR = 48;
    localparam int O_DIN = 4, O_DOUT = 8, O_MODE = 12, O_PUD = 16;
    localparam int O_EVT = 20, O_IEN = 24, O_FRC = 28, O_EDGE = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pad_in = '0;
    logic [NPIN-1:0] pad_oe, pad_out, pad_pull_en;
    logic [NP-1:0]   irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpgpio_ctrl #(.NPORTS(NP), .VERSION(7'd3), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #1;
        d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_oe(input logic [15:0] m, input logic [7:0] d);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            case (m[2*b +: 2])
                2'd0: r[b] = 1'b0;
                2'd1: r[b] = 1'b1;
                2'd2: r[b] = ~d[b];
                default: r[b] = d[b];
            endcase
        end
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [7:0]  dpat [3];
        dpat[0] = 8'h00; dpat[1] = 8'hFF; dpat[2] = 8'hA5;

        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        for (int p = 0; p < NP; p++) begin
            for (int o = 4; o <= 32; o += 4) begin
                rd(p*STR + o, v); chk("R1 reset reg", v, 32'h0);
            end
        end
        chk("R1 reset oe", 32'(pad_oe), 32'h0);
        chk("R1 reset irq", 32'(irq), 32'h0);
        chk("R1 reset pull", 32'(pad_pull_en), 32'h0000FFFF);
        rd(0, v); chk("R1 reset ctrl", v, 32'h0000040C);

        // R2 control word: ports=2 at 15:9, version=3 at 8:2
        wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 ctrl all ones", v, 32'h0000040F);
        wr(0, 32'h2); rd(0, v); chk("R2 ctrl sync bit", v, 32'h0000040E);
        wr(0, 32'h1); rd(0, v); chk("R2 ctrl clkreq", v, 32'h0000040D);

        // R13 readback masks
        for (int p = 0; p < NP; p++) begin
            wr(p*STR + O_MODE, 32'hFFFF_FFFF); rd(p*STR + O_MODE, v);
            chk("R13 mode mask", v, 32'h0000FFFF);
            wr(p*STR + O_PUD, 32'hFFFF_FF3C); rd(p*STR + O_PUD, v);
            chk("R13 pud mask", v, 32'h3C);
            chk("R4 pull inverse", 32'(pad_pull_en[p*8 +: 8]), 32'hC3);
            wr(p*STR + O_PUD, 32'h0);
            wr(p*STR + O_IEN, 32'h1_5A); rd(p*STR + O_IEN, v);
            chk("R13 ien mask", v, 32'h5A);
            wr(p*STR + O_IEN, 32'h0);
            wr(p*STR + O_EDGE, 32'h7_C3); rd(p*STR + O_EDGE, v);
            chk("R13 edge mask", v, 32'hC3);
        end

        // R3 full sweep of mode codes and output patterns, uniform and mixed
        for (int p = 0; p < NP; p++) begin
            for (int m = 0; m < 5; m++) begin
                logic [15:0] mv;
                mv = (m < 4) ? 16'(m * 16'h5555) : 16'hE4E4;
                wr(p*STR + O_MODE, 32'(mv));
                for (int k = 0; k < 3; k++) begin
                    wr(p*STR + O_DOUT, 32'(dpat[k]));
                    chk("R3 pad oe", 32'(pad_oe[p*8 +: 8]), 32'(exp_oe(mv, dpat[k])));
                    chk("R3 pad out", 32'(pad_out[p*8 +: 8]), 32'(dpat[k]));
                    chk("R3 other port", 32'(pad_oe[(1-p)*8 +: 8]), 32'h0);
                end
                wr(p*STR + O_MODE, 32'h0);
            end
            wr(p*STR + O_DOUT, 32'h0);
        end

        // R5 input latency; R10 gate off first so these edges set nothing
        wr(0, 32'h0);
        for (int k = 0; k < 4; k++) begin
            logic [15:0] pat, old;
            old = pad_in;
            pat = 16'(16'h1234 * (k + 1) ^ 16'hA5C3);
            pad_in = pat;
            cyc(1);
            rd(O_DIN, v); chk("R5 din not yet", v, 32'(old[7:0]));
            cyc(1);
            rd(O_DIN, v); chk("R5 din port0", v, 32'(pat[7:0]));
            rd(STR + O_DIN, v); chk("R5 din port1", v, 32'(pat[15:8]));
        end
        pad_in = '0;
        cyc(3);
        for (int p = 0; p < NP; p++) begin
            rd(p*STR + O_EVT, v); chk("R10 gated no events", v, 32'h0);
        end
        wr(0, 32'h1);
        cyc(3);

        // R6 every pin, both polarities, both directions
        for (int pin = 0; pin < NPIN; pin++) begin
            for (int pol = 0; pol < 2; pol++) begin
                int p, b;
                p = pin / 8; b = pin % 8;
                wr(p*STR + O_EDGE, pol ? 32'hFF : 32'h00);
                pad_in[pin] = 1'b1;
                cyc(3);
                rd(p*STR + O_EVT, v);
                chk("R6 rise", v, pol ? 32'(1 << b) : 32'h0);
                wr(p*STR + O_EVT, 32'hFF);
                pad_in[pin] = 1'b0;
                cyc(3);
                rd(p*STR + O_EVT, v);
                chk("R6 fall", v, pol ? 32'h0 : 32'(1 << b));
                wr(p*STR + O_EVT, 32'hFF);
            end
        end

        // R7 partial clear
        wr(O_EDGE, 32'h00);
        pad_in[7:0] = 8'hFF; cyc(3);
        pad_in[7:0] = 8'h00; cyc(3);
        rd(O_EVT, v); chk("R7 all set", v, 32'hFF);
        wr(O_EVT, 32'h0F);
        rd(O_EVT, v); chk("R7 partial clear", v, 32'hF0);

        // R8 interrupt line
        wr(O_IEN, 32'h80);
        chk("R8 irq enabled pin", 32'(irq), 32'h1);
        wr(O_IEN, 32'h0F);
        chk("R8 irq masked", 32'(irq), 32'h0);
        wr(O_EVT, 32'hFF);
        wr(O_IEN, 32'h00);

        // R9 force
        wr(STR + O_IEN, 32'h01);
        wr(STR + O_FRC, 32'h21);
        cyc(1);
        rd(STR + O_EVT, v); chk("R9 forced flags", v, 32'h21);
        chk("R9 forced irq", 32'(irq), 32'h2);
        wr(STR + O_EVT, 32'hFF);
        rd(STR + O_EVT, v); chk("R9 clear loses to force", v, 32'h21);
        rd(STR + O_FRC, v); chk("R9 force readback", v, 32'h21);
        wr(STR + O_FRC, 32'h0);
        wr(STR + O_EVT, 32'hFF);
        rd(STR + O_EVT, v); chk("R9 cleared after unforce", v, 32'h0);
        chk("R9 irq dropped", 32'(irq), 32'h0);
        wr(STR + O_IEN, 32'h0);

        // R10 gating and no stale event on resume
        wr(O_EDGE, 32'hFF);
        wr(0, 32'h0);
        pad_in[0] = 1'b1; cyc(3);
        rd(O_EVT, v); chk("R10 gated rise ignored", v, 32'h0);
        wr(0, 32'h1); cyc(3);
        rd(O_EVT, v); chk("R10 no stale event", v, 32'h0);
        pad_in[0] = 1'b0; cyc(3);
        pad_in[0] = 1'b1; cyc(3);
        rd(O_EVT, v); chk("R10 resumed", v, 32'h1);

        // R12 edge lands on the clear cycle
        pad_in[0] = 1'b0; cyc(3);
        pad_in[0] = 1'b1;
        cyc(1);
        wr(O_EVT, 32'h1);
        rd(O_EVT, v); chk("R12 set wins", v, 32'h1);
        wr(O_EVT, 32'h1);
        rd(O_EVT, v); chk("R12 plain clear", v, 32'h0);

        // R11 decode holes
        wr(O_DOUT, 32'h3C);
        wr(O_DOUT + 1, 32'hFF);
        rd(O_DOUT, v); chk("R11 unaligned write ignored", v, 32'h3C);
        rd(O_DOUT + 1, v); chk("R11 unaligned read", v, 32'h0);
        wr(STR, 32'hFFFF_FFFF);
        rd(STR, v); chk("R11 port1 offset0", v, 32'h0);
        rd(0, v); chk("R11 ctrl untouched", v, 32'h0000040D);
        wr(O_EDGE + 4, 32'hFF); rd(O_EDGE + 4, v); chk("R11 offset 0x24", v, 32'h0);
        rd(STR + 44, v); chk("R11 offset 0x2C", v, 32'h0);
        wr(2*STR + O_DOUT, 32'hFF);
        rd(2*STR + O_DOUT, v); chk("R11 absent port", v, 32'h0);
        chk("R11 pads unchanged", 32'(pad_out), 32'h003C);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule